// File: doc/BRIEF.md
# Packed SIMD integer ALU

This block is a registered arithmetic unit that operates on two 64-bit operands. A lane-size input makes one 64-bit datapath act as eight 8-bit lanes, four 16-bit lanes, two 32-bit lanes or a single 64-bit integer. One operation is applied to every lane in the same cycle. Carries and borrows stop at each lane boundary.

Add and subtract are available with wraparound arithmetic. For 8-bit and 16-bit lanes they are also available with signed or unsigned saturation. Bitwise AND, OR and XOR always act on the whole word. The block performs integer operations only.

The result is registered. It appears on the output one clock after the inputs are sampled.

Top module: `simd_alu`

## Requirements
- R1: While `rst` is high at a rising clock edge, `res_o` becomes all zeros. Otherwise `res_o` takes the result of the inputs sampled at the previous rising edge, which is one cycle of latency.
- R2: With `op_i` = 000 (add) and mode wrap (`mode_i` = 00), each lane of `res_o` is the lane sum modulo 2^width. `size_i` encodes the lane width as 00 = 8, 01 = 16, 10 = 32 and 11 = 64 bits. Lane k occupies bits [k*width+width-1 : k*width]. No carry enters lane k+1 from lane k.
- R3: With `op_i` = 001 (subtract) and mode wrap, each lane is lane(a) minus lane(b) modulo 2^width. No borrow crosses a lane boundary.
- R4: With mode 01 (signed saturation) at 8-bit or 16-bit lanes, an add or subtract whose two's-complement result overflows clamps. The lane becomes 0x7F or 0x7FFF on positive overflow, and 0x80 or 0x8000 on negative overflow.
- R5: With mode 10 (unsigned saturation) at 8-bit or 16-bit lanes, an add that overflows gives all ones in that lane, and a subtract that underflows gives zero.
- R6: Saturating modes at 32-bit or 64-bit lane size behave exactly like wraparound.
- R7: `op_i` = 010, 011 and 100 give a AND b, a OR b and a XOR b over all 64 bits, whatever `size_i` and `mode_i` are.
- R8: Unused opcodes 101, 110 and 111 give an all-zero result. Mode 11 behaves as wraparound.
- R9: At lane size 11 the operands are treated as single 64-bit integers, and a carry propagates across all 64 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand (subtrahend for subtract) |
| op_i | input | 3 | Operation: 000 add, 001 sub, 010 and, 011 or, 100 xor |
| mode_i | input | 2 | 00 wrap, 01 signed saturate, 10 unsigned saturate, 11 wrap |
| size_i | input | 2 | Lane width: 00 8-bit, 01 16-bit, 10 32-bit, 11 64-bit |
| res_o | output | 64 | Registered result |

## Verification
Each lane is filled with all ones and the other operand with lane-wise ones. A carry that leaks across a lane boundary then shows up as a non-zero byte, which separates the lane cuts from a full-width adder. Operand pairs at 0x7F/0x80 and 0xFF/0x00 in every lane distinguish signed clamping, unsigned clamping and wraparound. The same pairs at 32-bit and 64-bit width show that saturation falls back to wraparound there. A pseudo-random sweep over every opcode, mode and size is then compared with a lane-by-lane model, which covers mixed lane signs and reserved codes.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;
  localparam logic [2:0] OP_ADD = 3'b000;
  localparam logic [2:0] OP_SUB = 3'b001;
  localparam logic [2:0] OP_AND = 3'b010;
  localparam logic [2:0] OP_OR  = 3'b011;
  localparam logic [2:0] OP_XOR = 3'b100;

  typedef enum logic [1:0] {
    MODE_WRAP = 2'b00,
    MODE_SSAT = 2'b01,
    MODE_USAT = 2'b10,
    MODE_RSVD = 2'b11
  } sat_mode_e;
endpackage

// File: rtl/simd_lane_addsub.sv
module simd_lane_addsub #(
  parameter int W      = 8,
  parameter bit SAT_OK = 1'b1
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic         ssat_i,
  input  logic         usat_i,
  output logic [W-1:0] y_o
);
  logic [W-1:0] b_eff;
  logic [W:0]   sum;
  logic [W-1:0] wrap;
  logic         s_ovf;
  logic         u_out;

  always_comb begin
    b_eff = sub_i ? ~b_i : b_i;
    sum   = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};
    wrap  = sum[W-1:0];
    s_ovf = (a_i[W-1] == b_eff[W-1]) && (wrap[W-1] != a_i[W-1]);
    u_out = sub_i ? ~sum[W] : sum[W];
    y_o   = wrap;
    if (SAT_OK) begin
      if (ssat_i && s_ovf)
        y_o = a_i[W-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
      else if (usat_i && u_out)
        y_o = sub_i ? '0 : '1;
    end
  end

  always_comb begin
    if (SAT_OK && usat_i && !ssat_i) begin
      if (!sub_i) begin
        assert_usat_add_R5: assert (y_o >= a_i);
      end else begin
        assert_usat_sub_R5: assert (y_o <= a_i);
      end
    end
    if (SAT_OK && ssat_i && !usat_i && !sub_i && !a_i[W-1] && !b_i[W-1]) begin
      assert_ssat_pos_R4: assert (!y_o[W-1]);
    end
  end
endmodule

// File: rtl/simd_addsub.sv
module simd_addsub
  import simd_alu_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int MIN_W     = 8,
  parameter int SAT_MAX_W = 16,
  parameter int SIZE_W    = 2
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  input  logic [1:0]        mode_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic [DATA_W-1:0] y_o
);
  localparam int NUM_SIZES = 1 << SIZE_W;

  logic              ssat;
  logic              usat;
  logic [DATA_W-1:0] cand [NUM_SIZES];

  assign ssat = (mode_i == MODE_SSAT);
  assign usat = (mode_i == MODE_USAT);

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
    localparam int LW  = MIN_W << g;
    localparam int NL  = DATA_W / LW;
    localparam bit SAT = (LW <= SAT_MAX_W);
    for (genvar l = 0; l < NL; l++) begin : g_lane
      simd_lane_addsub #(.W(LW), .SAT_OK(SAT)) i_lane (
        .a_i    (a_i[l*LW +: LW]),
        .b_i    (b_i[l*LW +: LW]),
        .sub_i  (sub_i),
        .ssat_i (ssat),
        .usat_i (usat),
        .y_o    (cand[g][l*LW +: LW])
      );
    end
  end

  assign y_o = cand[size_i];
endmodule

// File: rtl/simd_alu.sv
module simd_alu
  import simd_alu_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int MIN_W     = 8,
  parameter int SAT_MAX_W = 16,
  parameter int SIZE_W    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [2:0]        op_i,
  input  logic [1:0]        mode_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic [DATA_W-1:0] res_o
);
  logic [DATA_W-1:0] arith;
  logic [DATA_W-1:0] nxt;

  simd_addsub #(
    .DATA_W(DATA_W), .MIN_W(MIN_W), .SAT_MAX_W(SAT_MAX_W), .SIZE_W(SIZE_W)
  ) i_addsub (
    .a_i    (a_i),
    .b_i    (b_i),
    .sub_i  (op_i == OP_SUB),
    .mode_i (mode_i),
    .size_i (size_i),
    .y_o    (arith)
  );

  always_comb begin
    case (op_i)
      OP_ADD, OP_SUB: nxt = arith;
      OP_AND:         nxt = a_i & b_i;
      OP_OR:          nxt = a_i | b_i;
      OP_XOR:         nxt = a_i ^ b_i;
      default:        nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) res_o <= '0;
    else     res_o <= nxt;
  end

  assert_reset_R1: assert property (@(posedge clk) rst |=> (res_o == '0));

  assert_and_subset_R7: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_AND) |=> (((res_o & ~$past(a_i)) == '0) && ((res_o & ~$past(b_i)) == '0)));

  assert_or_superset_R7: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_OR) |=> ((($past(a_i) | $past(b_i)) & ~res_o) == '0));

  assert_bad_op_R8: assert property (@(posedge clk) disable iff (rst)
    (op_i > OP_XOR) |=> (res_o == '0));
endmodule

// File: tb/test_simd_alu.sv
`timescale 1ns/1ps
module test_simd_alu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] a = '0, b = '0;
  logic [2:0]  op = '0;
  logic [1:0]  mode = '0;
  logic [1:0]  size = '0;
  logic [63:0] res;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  simd_alu i_simd_alu (
    .clk(clk), .rst(rst), .a_i(a), .b_i(b), .op_i(op),
    .mode_i(mode), .size_i(size), .res_o(res)
  );

  function automatic logic [63:0] model(input logic [63:0] x, input logic [63:0] y,
                                        input logic [2:0] o, input logic [1:0] m,
                                        input logic [1:0] s);
    logic [63:0] r, mask, lx, ly, lr;
    longint sx, sy, t, lim;
    int w;
    r = '0;
    case (o)
      3'b010: r = x & y;
      3'b011: r = x | y;
      3'b100: r = x ^ y;
      3'b000, 3'b001: begin
        w = 8 << s;
        mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        for (int l = 0; l < 64 / w; l++) begin
          lx = (x >> (l * w)) & mask;
          ly = (y >> (l * w)) & mask;
          lr = ((o == 3'b001) ? (lx - ly) : (lx + ly)) & mask;
          if (w <= 16 && m == 2'b01) begin
            lim = longint'(1) << (w - 1);
            sx = (longint'(lx) >= lim) ? longint'(lx) - 2 * lim : longint'(lx);
            sy = (longint'(ly) >= lim) ? longint'(ly) - 2 * lim : longint'(ly);
            t = (o == 3'b001) ? sx - sy : sx + sy;
            if (t > lim - 1) t = lim - 1;
            if (t < -lim) t = -lim;
            lr = 64'(t) & mask;
          end else if (w <= 16 && m == 2'b10) begin
            t = (o == 3'b001) ? longint'(lx) - longint'(ly) : longint'(lx) + longint'(ly);
            if (t > longint'(mask)) t = longint'(mask);
            if (t < 0) t = 0;
            lr = 64'(t);
          end
          r = r | (lr << (l * w));
        end
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic apply(input logic [63:0] x, input logic [63:0] y, input logic [2:0] o,
                       input logic [1:0] m, input logic [1:0] s);
    @(negedge clk);
    a = x; b = y; op = o; mode = m; size = s;
    @(negedge clk);
  endtask

  task automatic run(input string tag, input logic [63:0] x, input logic [63:0] y,
                     input logic [2:0] o, input logic [1:0] m, input logic [1:0] s,
                     input logic [63:0] exp);
    apply(x, y, o, m, s);
    check(tag, res, exp);
  endtask

  task automatic t_reset;
    apply(64'h1234, 64'h1, 3'b000, 2'b00, 2'b00);
    check("R1 reset holds zero", res, 64'h0);
    rst = 1'b0;
    apply(64'h1234, 64'h1, 3'b000, 2'b00, 2'b00);
    check("R1 one-cycle result", res, 64'h1235);
  endtask

  task automatic t_wrap_add;
    run("R2 8-bit no carry", 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 3'b000, 2'b00, 2'b00, 64'h0);
    run("R2 16-bit no carry", 64'hFFFF_FFFF_FFFF_FFFF, 64'h0001_0001_0001_0001, 3'b000, 2'b00, 2'b01, 64'h0);
    run("R2 32-bit lanes", 64'hFFFF_FFFF_0000_0001, 64'h0000_0001_0000_0002, 3'b000, 2'b00, 2'b10, 64'h0000_0000_0000_0003);
  endtask

  task automatic t_wrap_sub;
    run("R3 8-bit no borrow", 64'h0, 64'h0101_0101_0101_0101, 3'b001, 2'b00, 2'b00, 64'hFFFF_FFFF_FFFF_FFFF);
    run("R3 16-bit lanes", 64'h0005_0000_0010_8000, 64'h0003_0001_0010_0001, 3'b001, 2'b00, 2'b01, 64'h0002_FFFF_0000_7FFF);
  endtask

  task automatic t_ssat;
    run("R4 8-bit positive clamp", 64'h7F7F_7F7F_7F7F_7F7F, 64'h0101_0101_0101_0101, 3'b000, 2'b01, 2'b00, 64'h7F7F_7F7F_7F7F_7F7F);
    run("R4 8-bit negative clamp", 64'h8080_8080_8080_8080, 64'h0101_0101_0101_0101, 3'b001, 2'b01, 2'b00, 64'h8080_8080_8080_8080);
    run("R4 16-bit mixed", 64'h7FFF_8000_0010_FFFF, 64'h0001_0001_0005_0001, 3'b000, 2'b01, 2'b01, 64'h7FFF_8001_0015_0000);
  endtask

  task automatic t_usat;
    run("R5 8-bit add clamp", 64'hFFF0_0102_0304_0506, 64'h0120_0101_0101_0101, 3'b000, 2'b10, 2'b00, 64'hFFFF_0203_0405_0607);
    run("R5 16-bit sub floor", 64'h0000_0005_FFFF_0001, 64'h0001_0006_0001_0001, 3'b001, 2'b10, 2'b01, 64'h0000_0000_FFFE_0000);
  endtask

  task automatic t_fallback;
    run("R6 32-bit usat wraps", 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0001, 3'b000, 2'b10, 2'b10, 64'h0);
    run("R6 64-bit ssat wraps", 64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 3'b000, 2'b01, 2'b11, 64'h8000_0000_0000_0000);
  endtask

  task automatic t_logic;
    run("R7 and", 64'hF0F0_1234_FFFF_0000, 64'hFF00_0FF0_AAAA_FFFF, 3'b010, 2'b01, 2'b00, 64'hF000_0230_AAAA_0000);
    run("R7 or", 64'hF0F0_1234_0000_0000, 64'h0F00_0FF0_5555_0001, 3'b011, 2'b10, 2'b01, 64'hFFF0_1FF4_5555_0001);
    run("R7 xor", 64'hFFFF_0000_1234_5678, 64'hFFFF_FFFF_1234_0000, 3'b100, 2'b11, 2'b11, 64'h0000_FFFF_0000_5678);
  endtask

  task automatic t_reserved;
    run("R8 op 101 zero", 64'hFFFF, 64'hFFFF, 3'b101, 2'b00, 2'b00, 64'h0);
    run("R8 op 111 zero", 64'h1, 64'h2, 3'b111, 2'b00, 2'b11, 64'h0);
    run("R8 mode 11 wraps", 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 3'b000, 2'b11, 2'b00, 64'h0);
  endtask

  task automatic t_full64;
    run("R9 64-bit carry", 64'h0000_0000_FFFF_FFFF, 64'h1, 3'b000, 2'b00, 2'b11, 64'h0000_0001_0000_0000);
    run("R9 64-bit borrow", 64'h0001_0000_0000_0000, 64'h1, 3'b001, 2'b00, 2'b11, 64'h0000_FFFF_FFFF_FFFF);
  endtask

  task automatic t_sweep;
    logic [63:0] x = 64'h9E37_79B9_7F4A_7C15;
    logic [63:0] y = 64'h2545_F491_4F6C_DD1D;
    for (int i = 0; i < 320; i++) begin
      logic [2:0] o = 3'(i % 8);
      logic [1:0] m = 2'((i / 8) % 4);
      logic [1:0] s = 2'((i / 32) % 4);
      x = {x[62:0], x[63] ^ x[62] ^ x[60] ^ x[59]};
      y = y * 64'h5851_F42D_4C95_7F2D + 64'd1;
      run("R2 R3 R4 R5 R6 R7 R8 R9 sweep", x, y, o, m, s, model(x, y, o, m, s));
    end
  endtask

  initial begin
    t_reset;
    t_wrap_add;
    t_wrap_sub;
    t_ssat;
    t_usat;
    t_fallback;
    t_logic;
    t_reserved;
    t_full64;
    t_sweep;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule